// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers characters from an asynchronous serial line. The line idles high. A high-to-low transition marks the beginning of a character. The block samples every bit near its centre using an internal oversampling tick. The tick runs at sixteen times the bit rate and comes from a clock divisor input. The character format is selected at run time: five to eight data bits, optional even or odd parity, and one or two stop bits.

Each character is delivered on a parallel data output together with a one-cycle valid strobe. A parity-error flag and a framing-error flag accompany the strobe. Every start edge restarts the bit timing, so accumulated drift never carries from one character to the next. The receiver is ready for a new character at the centre of the final stop bit, which lets frames arrive back to back with no idle time between them.

Top module: `uart_rx`

## Requirements
- R1: While rst_ni is low and after its release, valid_o, parity_err_o and frame_err_o are 0 and data_o is 0.
- R2: A falling edge on the synchronised line starts a frame. If the line is high again at the centre of the start bit, the event is dropped and produces no valid_o.
- R3: The oversampling tick occurs once every divisor_i+1 clock cycles, and one bit lasts 16 ticks. The start bit is sampled on the 8th tick after its edge, and each later bit 16 ticks after the previous sample. Data is assembled least-significant bit first.
- R4: The data_bits_i code gives the data length: 0=5, 1=6, 2=7, 3=8 bits. The data_o bits above the selected length are 0.
- R5: When parity_en_i is 1, one parity bit follows the data. With parity_odd_i=0, parity_err_o is set when the data bits XOR the parity bit equals 1. With parity_odd_i=1, it is set when that XOR equals 0. When parity_en_i is 0, there is no parity bit and parity_err_o stays 0.
- R6: stop2_i=0 selects one stop bit and stop2_i=1 selects two. frame_err_o is set when any stop bit is sampled as 0.
- R7: A start bit that directly follows the last stop bit is received as a new character, and no character is lost.
- R8: valid_o is high for exactly one clock per character. data_o, parity_err_o and frame_err_o are valid in that cycle, and both flags are 0 whenever valid_o is 0.
- R9: The format inputs are captured at the start edge. Changing them during a frame does not alter that frame.
- R10: Frames separated by idle gaps of any length, including gaps that are not a multiple of the tick period, are all received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idles high |
| divisor_i | input | DIV_W | Tick period minus one, in clocks |
| data_bits_i | input | 2 | Data length code (0..3 gives 5..8 bits) |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| stop2_i | input | 1 | 1 selects two stop bits |
| data_o | output | 8 | Received character, right aligned |
| valid_o | output | 1 | One-cycle strobe per character |
| parity_err_o | output | 1 | Parity mismatch, qualified by valid_o |
| frame_err_o | output | 1 | Stop bit sampled low, qualified by valid_o |

## Verification
The tick-spacing assertion assumes divisor_i is held constant while the receiver is running. The bench therefore sets it once, before reset is released. The flag and width assertions rely on the format being latched at the start edge, so they hold even when the format pins move mid-frame, and one test moves them deliberately. Serial bits are driven on falling clock edges, with exactly 16·(divisor_i+1) clocks per bit. This keeps every centre sample well clear of bit boundaries, including across the added idle gaps.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } rx_fmt_t;
endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == divisor_i) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (cnt_q == divisor_i) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R3: with a divisor above zero, ticks never fall on adjacent cycles
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && divisor_i != '0) |=> !tick_o);
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic meta_q, line_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      line_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_i;
      line_q <= meta_q;
      prev_q <= line_q;
    end
  end

  assign line_o = line_q;
  assign fall_o = prev_q & ~line_q;

  // R2: an edge event lasts one cycle
  a_r2_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              fall_i,
  input  rx_fmt_t           fmt_i,
  output logic              restart_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int MID   = OSR / 2;
  localparam int BIT_W = $clog2(DATA_W);

  rx_state_e         state_q;
  rx_fmt_t           fmt_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic [BIT_W-1:0]  bcnt_q;
  logic [DATA_W-1:0] shift_q;
  logic              acc_q, perr_q, ferr_q, stop_idx_q;
  logic              sample;
  int unsigned       nbits;
  logic [DATA_W-1:0] aligned;

  assign restart_o = (state_q == ST_IDLE) && fall_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign nbits     = MIN_BITS + int'(fmt_q.len_code);
  assign aligned   = shift_q >> (DATA_W - nbits);

  always_comb begin
    if (state_q == ST_START) sample = tick_i && (tcnt_q == CNT_W'(MID - 1));
    else                     sample = tick_i && (tcnt_q == CNT_W'(OSR - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      fmt_q      <= '0;
      tcnt_q     <= '0;
      bcnt_q     <= '0;
      shift_q    <= '0;
      acc_q      <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
      stop_idx_q <= 1'b0;
      data_o     <= '0;
      valid_o    <= 1'b0;
      perr_o     <= 1'b0;
      ferr_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      if (state_q != ST_IDLE && tick_i) begin
        if (sample) tcnt_q <= '0;
        else        tcnt_q <= tcnt_q + 1'b1;
      end
      unique case (state_q)
        ST_IDLE: if (fall_i) begin
          fmt_q      <= fmt_i;
          tcnt_q     <= '0;
          bcnt_q     <= '0;
          acc_q      <= 1'b0;
          perr_q     <= 1'b0;
          ferr_q     <= 1'b0;
          stop_idx_q <= 1'b0;
          state_q    <= ST_START;
        end
        ST_START: if (sample) begin
          // line back high at the centre: treat as a glitch
          state_q <= line_i ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (sample) begin
          shift_q <= {line_i, shift_q[DATA_W-1:1]};
          acc_q   <= acc_q ^ line_i;
          if (bcnt_q == BIT_W'(nbits - 1)) begin
            bcnt_q  <= '0;
            state_q <= fmt_q.par_en ? ST_PAR : ST_STOP;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        ST_PAR: if (sample) begin
          perr_q  <= acc_q ^ line_i ^ fmt_q.par_odd;
          state_q <= ST_STOP;
        end
        ST_STOP: if (sample) begin
          if (fmt_q.two_stop && !stop_idx_q) begin
            stop_idx_q <= 1'b1;
            ferr_q     <= ~line_i;
          end else begin
            // ready for the next start edge from mid stop bit
            valid_o <= 1'b1;
            data_o  <= aligned;
            perr_o  <= perr_q & fmt_q.par_en;
            ferr_o  <= ferr_q | ~line_i;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r8_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r8_flags_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_o || ferr_o) |-> valid_o);
  a_r5_no_parity_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !fmt_q.par_en) |-> !perr_o);
  a_r4_short_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fmt_q.len_code == 2'd0) |-> (data_o[DATA_W-1:MIN_BITS] == '0));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic [1:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic             parity_odd_i,
  input  logic             stop2_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  output logic             parity_err_o,
  output logic             frame_err_o
);
  logic    line, fall, tick, restart, busy;
  rx_fmt_t fmt;

  assign fmt = '{len_code: data_bits_i, par_en: parity_en_i,
                 par_odd: parity_odd_i, two_stop: stop2_i};

  uart_rx_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .line_o (line),
    .fall_o (fall)
  );

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .divisor_i (divisor_i),
    .restart_i (restart),
    .tick_o    (tick)
  );

  uart_rx_fsm #(.OSR(OSR)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .line_i    (line),
    .fall_i    (fall),
    .fmt_i     (fmt),
    .restart_o (restart),
    .busy_o    (busy),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .perr_o    (parity_err_o),
    .ferr_o    (frame_err_o)
  );

  // R2: a frame only begins on a detected falling edge
  a_r2_busy_from_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(fall));
endmodule

// File: tb/sim_uart_rx.sv
`timescale 1ns/1ps
module sim_uart_rx;
  localparam int DIV = 3;
  localparam int BIT = 16 * (DIV + 1);
  localparam int NV  = 8;
  // {len_code[1:0], par_en, par_odd, two_stop, byte[7:0], bad_par, bad_stop}
  localparam logic [14:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b0, 8'h57, 1'b1, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b1, 8'h2A, 1'b0, 1'b1},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1},
    {2'd2, 1'b0, 1'b0, 1'b1, 8'hFE, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic [15:0] divisor = 16'(DIV);
  logic [1:0] data_bits = 2'd3;
  logic par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic [7:0] data;
  logic valid, perr, ferr;
  int checks = 0, fails = 0, ncap = 0, wide = 0;
  logic vprev = 1'b0;
  logic [7:0] cap_d [64];
  logic cap_p [64], cap_f [64];

  always #10 clk = ~clk;

  uart_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .divisor_i(divisor),
    .data_bits_i(data_bits), .parity_en_i(par_en), .parity_odd_i(par_odd),
    .stop2_i(stop2), .data_o(data), .valid_o(valid),
    .parity_err_o(perr), .frame_err_o(ferr)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid && ncap < 64) begin
        cap_d[ncap] = data; cap_p[ncap] = perr; cap_f[ncap] = ferr;
        ncap++;
      end
      if (valid && vprev) wide++;
      if (!valid && (perr || ferr)) wide++;
      vprev = valid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bits(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic [1:0] code, input logic pe,
                      input logic odd, input logic s2, input logic bp, input logic bs,
                      input bit scramble);
    int nb = 5 + int'(code);
    logic [7:0] m = 8'((9'd1 << nb) - 1);
    data_bits = code; par_en = pe; par_odd = odd; stop2 = s2;
    rx = 1'b0; bits(BIT);
    if (scramble) begin
      data_bits = ~code; par_en = ~pe; par_odd = ~odd; stop2 = ~s2;
    end
    for (int i = 0; i < nb; i++) begin rx = b[i]; bits(BIT); end
    if (pe) begin rx = (^(b & m)) ^ odd ^ bp; bits(BIT); end
    rx = ~bs; bits(BIT);
    if (s2) begin rx = 1'b1; bits(BIT); end
    rx = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    bits(4);
    // R1: outputs during reset
    check(valid == 0 && perr == 0 && ferr == 0 && data == 0, "R1", {data, valid, perr, ferr}, 0);
    rst_n = 1'b1;
    bits(20);
    check(valid == 0 && data == 0 && ncap == 0, "R1", {data, valid}, 0);

    // R3 R4 R5 R6 R10: table walk with uneven idle gaps
    for (int v = 0; v < NV; v++) begin
      logic [14:0] e = VEC[v];
      int nb = 5 + int'(e[14:13]);
      logic [7:0] m = 8'((9'd1 << nb) - 1);
      base = ncap;
      bits(v * 7 + 3);
      send(e[9:2], e[14:13], e[12], e[11], e[10], e[1], e[0], 1'b0);
      bits(4);
      check(ncap == base + 1 && cap_d[base] == (e[9:2] & m)
            && cap_p[base] == (e[1] & e[12]) && cap_f[base] == e[0],
            "R3 R4 R5 R6 R10", {cap_d[base], cap_p[base], cap_f[base]},
            {e[9:2] & m, e[1] & e[12], e[0]});
    end

    // R2: short low pulse rejected
    base = ncap;
    rx = 1'b0; bits(10); rx = 1'b1; bits(3 * BIT);
    check(ncap == base, "R2", ncap - base, 0);

    // R7: back-to-back frames, no idle between
    base = ncap;
    send(8'h5A, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'hC3, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(8'h0F, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bits(4);
    check(ncap == base + 3, "R7", ncap - base, 3);
    check(cap_d[base] == 8'h5A && cap_d[base+1] == 8'hC3 && cap_d[base+2] == 8'h0F
          && !cap_p[base] && !cap_f[base+1] && !cap_f[base+2], "R7",
          {cap_d[base], cap_d[base+1], cap_d[base+2]}, 24'h5AC30F);

    // R9: format pins move after the start bit
    base = ncap;
    send(8'h96, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    data_bits = 2'd3; par_en = 1'b0; par_odd = 1'b0; stop2 = 1'b0;
    bits(2 * BIT);
    check(ncap == base + 1 && cap_d[base] == 8'h96 && !cap_p[base] && !cap_f[base],
          "R9", {cap_d[base], cap_p[base], cap_f[base]}, {8'h96, 2'b00});

    // R8: strobe width and flag qualification over the whole run
    check(wide == 0, "R8", wide, 0);
    check(ncap == NV + 4, "R8", ncap, NV + 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule